// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block takes 16-bit command words from a three-wire serial link (active-low chip select, serial clock and serial data) and applies them to a two-stage code path for a 14-bit converter. The first stage is a holding register and the second stage is the code the converter sees. The serial pins are asynchronous to the block. They are brought into a faster system clock through two-flop synchronizers, and their edges are found from the synchronized copies.

The first two bits of a word select one of four control codes. Three of the codes move data between the link, the holding register and the converter code. The fourth code reads the top three data bits as a sub-operation. A sub-operation can request shutdown, set or clear a user logic output, or choose how the serial data output is timed. A word takes effect when chip select rises, and only if exactly 16 clock rises were seen while chip select was low. The serial output is the bit leaving the end of the shift register, so several devices can be chained. In one timing mode it changes on serial clock rises. In the other it changes on serial clock falls, which adds half a clock of lag. The shutdown and wake policy sits in a separate block that listens to the request strobes.

Top module: `sdac_cmd_rx`

## Requirements
- R1: A word is 16 bits sent most significant bit first. Bits [15:14] are the control code and bits [13:0] are the data. A bit is captured on each synchronized rise of the serial clock while chip select is low. The word may arrive as one burst or as two 8-bit bursts with the clock idle between them, as long as chip select stays low.
- R2: A word executes when chip select rises, and only if exactly 16 clock rises were counted while it was low. A frame with any other count changes no output.
- R3: Control code 00 loads the data into the holding register. The converter code does not change and no strobe fires.
- R4: Control code 10 loads the data into both the holding register and the converter code, and fires a one-cycle wake strobe.
- R5: Control code 01 copies the holding register into the converter code and fires a one-cycle wake strobe.
- R6: With control code 11, data bits [13:11] equal to 00x do nothing, and 01x fire a one-cycle shutdown strobe.
- R7: With control code 11, data bits [13:11] equal to 100 fire the logic-output clear strobe, and 101 fire the logic-output set strobe.
- R8: With control code 11, data bits [13:11] equal to 110 select output timing mode 1, and 111 select mode 0. The mode is visible on `dout_mode_o` (0 or 1).
- R9: In mode 0, the serial output is updated on each serial clock rise taken while chip select is low. It then shows the bit that was captured 16 rises earlier.
- R10: In mode 1, the serial output does not change on rises. On each fall while chip select is low, it takes the bit that left the register at the rise before, so it trails the input by 16.5 clocks.
- R11: Reset clears the holding register and the converter code to 0, selects mode 0, clears the bit count, drives the serial output low and holds all strobes low.
- R12: Each strobe is high for exactly one system clock per executed command. At most one strobe is high in any cycle. The converter code changes only in a cycle where the wake strobe is high.
- R13: Writes to the holding register still take effect after a shutdown request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Chip select, active low, asynchronous |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out, taken from the end of the shift register |
| dac_code_o | output | DATA_W (14) | Converter code register |
| dout_mode_o | output | 1 | Output timing mode: 0 = rise-timed, 1 = fall-timed |
| shdn_req_o | output | 1 | Shutdown request strobe |
| wake_req_o | output | 1 | Wake request strobe |
| upo_set_o | output | 1 | Logic-output set strobe |
| upo_clr_o | output | 1 | Logic-output clear strobe |

## Verification
Code 10 does three things on the same system clock: it loads the holding register, loads the converter code and fires the wake strobe. The bench sends that code, both as one burst and as two split bursts. It then checks that the converter code and the wake count changed together. Later it issues a bare copy (code 01) and checks that the holding register kept the same value. A second overlap is the timing mode changing at a word boundary while the serial output keeps shifting. The bench keeps a behavioural history of every captured bit and compares the serial output after every rise and every fall. It does this across the frames where the mode changes, in both directions.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    CTL_LOAD_IN   = 2'b00,
    CTL_COPY      = 2'b01,
    CTL_LOAD_BOTH = 2'b10,
    CTL_SPECIAL   = 2'b11
  } ctl_e;

  localparam int SUBOP_W = 3;

  localparam logic [SUBOP_W-1:0] SUB_UPO_CLR = 3'b100;
  localparam logic [SUBOP_W-1:0] SUB_UPO_SET = 3'b101;
  localparam logic [SUBOP_W-1:0] SUB_MODE1   = 3'b110;
  localparam logic [SUBOP_W-1:0] SUB_MODE0   = 3'b111;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              din_s,
  input  logic              mode_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_ok_o,
  output logic              sclk_rise_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);

  logic              sclk_d, csn_d;
  logic              rise, fall, cs_rise;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              tail;
  logic              dout_q;

  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign cs_rise = csn_s & ~csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
      shreg  <= '0;
      cnt    <= '0;
      tail   <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
      if (csn_s) begin
        cnt <= '0;
      end else if (rise) begin
        shreg <= {shreg[WORD_W-2:0], din_s};
        tail  <= shreg[WORD_W-1];
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (!csn_s && rise && !mode_i)
        dout_q <= shreg[WORD_W-1];
      else if (!csn_s && fall && mode_i)
        dout_q <= tail;
    end
  end

  assign word_o      = shreg;
  assign word_ok_o   = cs_rise && (cnt == CNT_WORD);
  assign sclk_rise_o = rise;
  assign cnt_o       = cnt;
  assign dout_o      = dout_q;
endmodule

// File: rtl/sdac_decode.sv
module sdac_decode
  import sdac_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_ok_i,
  input  logic [DATA_W+1:0] word_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              mode_o,
  output logic              shdn_o,
  output logic              wake_o,
  output logic              upo_set_o,
  output logic              upo_clr_o
);
  ctl_e               ctl;
  logic [DATA_W-1:0]  data;
  logic [SUBOP_W-1:0] sub;
  logic [DATA_W-1:0]  in_q, dac_q;
  logic               mode_q, shdn_q, wake_q, set_q, clr_q;

  assign ctl  = ctl_e'(word_i[DATA_W+1:DATA_W]);
  assign data = word_i[DATA_W-1:0];
  assign sub  = data[DATA_W-1 -: SUBOP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q   <= '0;
      dac_q  <= '0;
      mode_q <= 1'b0;
      shdn_q <= 1'b0;
      wake_q <= 1'b0;
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      shdn_q <= 1'b0;
      wake_q <= 1'b0;
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
      if (word_ok_i) begin
        unique case (ctl)
          CTL_LOAD_IN: in_q <= data;
          CTL_LOAD_BOTH: begin
            in_q   <= data;
            dac_q  <= data;
            wake_q <= 1'b1;
          end
          CTL_COPY: begin
            dac_q  <= in_q;
            wake_q <= 1'b1;
          end
          CTL_SPECIAL: begin
            if (sub[2:1] == 2'b01) shdn_q <= 1'b1;
            else if (sub == SUB_UPO_CLR) clr_q <= 1'b1;
            else if (sub == SUB_UPO_SET) set_q <= 1'b1;
            else if (sub == SUB_MODE1) mode_q <= 1'b1;
            else if (sub == SUB_MODE0) mode_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign dac_code_o = dac_q;
  assign mode_o     = mode_q;
  assign shdn_o     = shdn_q;
  assign wake_o     = wake_q;
  assign upo_set_o  = set_q;
  assign upo_clr_o  = clr_q;
endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx #(
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              dout_mode_o,
  output logic              shdn_req_o,
  output logic              wake_req_o,
  output logic              upo_set_o,
  output logic              upo_clr_o
);
  localparam int WORD_W = DATA_W + 2;
  localparam int CNT_W  = $clog2(WORD_W) + 1;

  logic [2:0]        pins_s;
  logic              sclk_s, csn_s, din_s;
  logic [WORD_W-1:0] word;
  logic              word_ok;
  logic              sclk_rise;
  logic [CNT_W-1:0]  bit_cnt;

  sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) sync_i (
    .clk(clk), .rst(rst),
    .async_i({sclk_i, csn_i, din_i}),
    .sync_o(pins_s)
  );

  assign sclk_s = pins_s[2];
  assign csn_s  = pins_s[1];
  assign din_s  = pins_s[0];

  sdac_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) shift_i (
    .clk(clk), .rst(rst),
    .sclk_s(sclk_s), .csn_s(csn_s), .din_s(din_s),
    .mode_i(dout_mode_o),
    .word_o(word), .word_ok_o(word_ok),
    .sclk_rise_o(sclk_rise), .cnt_o(bit_cnt),
    .dout_o(dout_o)
  );

  sdac_decode #(.DATA_W(DATA_W)) dec_i (
    .clk(clk), .rst(rst),
    .word_ok_i(word_ok), .word_i(word),
    .dac_code_o(dac_code_o), .mode_o(dout_mode_o),
    .shdn_o(shdn_req_o), .wake_o(wake_req_o),
    .upo_set_o(upo_set_o), .upo_clr_o(upo_clr_o)
  );
endmodule

// File: rtl/sdac_cmd_rx_chk.sv
module sdac_cmd_rx_chk #(
  parameter int DATA_W = 14,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              csn_s,
  input logic              sclk_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              word_ok,
  input logic              dout_o,
  input logic [DATA_W-1:0] dac_code_o,
  input logic              dout_mode_o,
  input logic              shdn_req_o,
  input logic              wake_req_o,
  input logic              upo_set_o,
  input logic              upo_clr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({shdn_req_o, wake_req_o, upo_set_o, upo_clr_o}));

  assert_code_with_wake_R12: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code_o) |-> wake_req_o);

  assert_strobe_after_word_R2: assert property (@(posedge clk) disable iff (rst)
    (shdn_req_o || wake_req_o || upo_set_o || upo_clr_o) |-> $past(word_ok));

  assert_mode_after_word_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout_mode_o) |-> $past(word_ok));

  assert_bit_count_R1: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !csn_s && bit_cnt != CNT_MAX) |=>
      (bit_cnt == CNT_W'($past(bit_cnt) + 1'b1)));

  assert_dout_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $past(csn_s) |-> $stable(dout_o));
endmodule

bind sdac_cmd_rx sdac_cmd_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .csn_s(csn_s), .sclk_rise(sclk_rise),
  .bit_cnt(bit_cnt), .word_ok(word_ok), .dout_o(dout_o),
  .dac_code_o(dac_code_o), .dout_mode_o(dout_mode_o),
  .shdn_req_o(shdn_req_o), .wake_req_o(wake_req_o),
  .upo_set_o(upo_set_o), .upo_clr_o(upo_clr_o)
);

// File: tb/sdac_cmd_rx_tb.sv
module sdac_cmd_rx_tb_top;
  localparam int DW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, csn = 1'b1, din = 1'b0;
  logic dout, mode, shdn, wake, uset, uclr;
  logic [DW-1:0] code;

  int errors = 0, checks = 0, cyc = 0;
  int n_shdn = 0, n_wake = 0, n_set = 0, n_clr = 0;
  int e_shdn = 0, e_wake = 0, e_set = 0, e_clr = 0;
  logic [DW-1:0] e_in = '0, e_dac = '0;
  logic e_mode = 1'b0;
  logic hist[$];
  logic prev_str = 1'b0;

  always #5 clk = ~clk;

  sdac_cmd_rx dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .csn_i(csn), .din_i(din),
    .dout_o(dout), .dac_code_o(code), .dout_mode_o(mode),
    .shdn_req_o(shdn), .wake_req_o(wake), .upo_set_o(uset), .upo_clr_o(uclr)
  );

  task automatic chk(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Strobe monitor, sampled away from the active edge (R12)
  always @(negedge clk) begin
    if (!rst) begin
      if (shdn) n_shdn++;
      if (wake) n_wake++;
      if (uset) n_set++;
      if (uclr) n_clr++;
      if ((shdn | wake | uset | uclr) && prev_str) begin
        checks++; errors++;
        $display("FAIL R12 strobe wider than one cycle actual=1 expected=0");
      end
      if ((32'(shdn) + 32'(wake) + 32'(uset) + 32'(uclr)) > 1) begin
        checks++; errors++;
        $display("FAIL R12 strobes overlap actual=2 expected=1");
      end
      prev_str = shdn | wake | uset | uclr;
    end
  end

  function automatic logic hbit(input int idx);
    return (idx >= 0) ? hist[idx] : 1'b0;
  endfunction

  task automatic send_bit(input logic b);
    int k;
    din = b;
    repeat (8) @(posedge clk);
    sclk = 1'b1;
    k = hist.size();
    repeat (5) @(posedge clk);
    @(negedge clk);
    if (e_mode == 1'b0)
      chk("R9 dout after rise", dout == hbit(k - 16), dout, hbit(k - 16));
    else
      chk("R10 dout held at rise", dout == hbit(k - 17), dout, hbit(k - 17));
    hist.push_back(b);
    repeat (3) @(posedge clk);
    sclk = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    if (e_mode == 1'b1)
      chk("R10 dout after fall", dout == hbit(k - 16), dout, hbit(k - 16));
    repeat (3) @(posedge clk);
  endtask

  task automatic exec_model(input logic [15:0] w);
    logic [DW-1:0] d;
    d = w[DW-1:0];
    case (w[15:14])
      2'b00: e_in = d;
      2'b10: begin e_in = d; e_dac = d; e_wake++; end
      2'b01: begin e_dac = e_in; e_wake++; end
      default: begin
        if (d[13:12] == 2'b01) e_shdn++;
        else if (d[13:11] == 3'b100) e_clr++;
        else if (d[13:11] == 3'b101) e_set++;
        else if (d[13:11] == 3'b110) e_mode = 1'b1;
        else if (d[13:11] == 3'b111) e_mode = 1'b0;
      end
    endcase
  endtask

  task automatic check_state(input string tag);
    chk(tag, code == e_dac, 32'(code), 32'(e_dac));
    chk(tag, mode == e_mode, 32'(mode), 32'(e_mode));
    chk(tag, n_wake == e_wake, n_wake, e_wake);
    chk(tag, n_shdn == e_shdn, n_shdn, e_shdn);
    chk(tag, (n_set == e_set) && (n_clr == e_clr), n_set * 16 + n_clr, e_set * 16 + e_clr);
  endtask

  task automatic frame(input logic [31:0] bits, input int n, input int split, input string tag);
    csn = 1'b0;
    repeat (8) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      if (split > 0 && i == split) repeat (30) @(posedge clk);
      send_bit(bits[n-1-i]);
    end
    repeat (8) @(posedge clk);
    csn = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk);
    if (n == 16) exec_model(bits[15:0]);
    check_state(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R11 reset code", code == '0, 32'(code), 0);
    chk("R11 reset mode", mode == 1'b0, 32'(mode), 0);
    chk("R11 reset dout", dout == 1'b0, 32'(dout), 0);
    chk("R11 reset strobes", (shdn | wake | uset | uclr) == 1'b0, 1, 0);

    frame(32'h0000_1234, 16, 0, "R3 load holding only");
    frame(32'h0000_4000, 16, 0, "R5 copy holding to code");
    frame(32'h0000_BABC, 16, 0, "R4 load both and wake");
    frame(32'h0000_8155, 16, 8, "R1 split burst load both");
    frame(32'h0000_4000, 16, 0, "R4 holding kept after load both");
    frame(32'h0000_0777, 15, 0, "R2 short frame discarded");
    frame(32'h0001_7FFF, 17, 0, "R2 long frame discarded");
    frame(32'hABCD_4000, 32, 0, "R2 double word discarded");
    frame(32'h0000_C000, 16, 0, "R6 no-op 000");
    frame(32'h0000_C800, 16, 0, "R6 no-op 001");
    frame(32'h0000_D000, 16, 0, "R6 shutdown 010");
    frame(32'h0000_D800, 16, 0, "R6 shutdown 011");
    frame(32'h0000_2222, 16, 0, "R13 holding write after shutdown");
    frame(32'h0000_4000, 16, 0, "R13 copy after shutdown");
    frame(32'h0000_E000, 16, 0, "R7 logic output clear");
    frame(32'h0000_E800, 16, 8, "R7 logic output set");
    frame(32'h0000_F000, 16, 0, "R8 select mode 1");
    frame(32'h0000_9A5A, 16, 0, "R10 load in mode 1");
    frame(32'h0000_35C3, 16, 8, "R10 split in mode 1");
    frame(32'h0000_F800, 16, 0, "R8 select mode 0");
    frame(32'h0000_0F0F, 16, 0, "R9 load in mode 0");
    frame(32'h0000_4000, 16, 0, "R12 copy strobe count");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule